// File: doc/BRIEF.md
# Change-Detect Interrupt Status Controller

This block watches a group of level-type status flags coming from a video receiver, such as packet-seen, mute and mode indications. Whenever one of these flags changes value, rising or falling, a sticky status bit for that flag is latched. The bit then stays set until software clears it.

The status bits are packed into two 8-bit words. Word 0 carries five live event bits in positions 4 down to 0, and word 1 carries eight live event bits. Two independent mask sets choose which status bits reach each of the two interrupt lines, `irq_a` and `irq_b`.

A small byte-wide register port gives software access to the block. Through it, software reads the status words, reads and writes both mask sets, and clears single status bits by writing ones to a clear register.

Top module: `chg_irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, all status bits, both mask sets and both interrupt lines are 0. Releasing reset never latches an event, even when `raw_in` is nonzero.
- R2: A 0-to-1 change on a used `raw_in` bit sets its status bit. The bit is not visible at the end of the clock edge that samples the change. It reads 1 after the following edge.
- R3: A 1-to-0 change on a used `raw_in` bit sets its status bit, with the same two-edge timing as R2.
- R4: A set status bit stays 1 when its raw input changes again. Only a clear write removes it.
- R5: Writing to a clear address (word 0 at 0x2, word 1 at 0x3) clears each status bit written as 1 and leaves each bit written as 0 unchanged. A read of a clear address returns 0.
- R6: When a raw change and a clear of the same bit fall on the same clock edge, the bit ends up 1.
- R7: The status words (word 0 at 0x0, word 1 at 0x1) are read-only. Writes to them change nothing.
- R8: Status word 0 bits 7..5 always read 0. `raw_in[7:5]` have no effect. `raw_in[4:0]` map to word 0 bits 4..0, and `raw_in[15:8]` map to word 1 bits 7..0.
- R9: Mask set A (0x4 word 0, 0x5 word 1) and mask set B (0x6, 0x7) are 8-bit read/write registers. Each reads back the last value written to it.
- R10: `irq_a` is 1 exactly when some status bit is set together with its mask A bit. `irq_b` behaves the same way using mask set B, independently of `irq_a`.
- R11: Addresses 0x8 to 0xF read 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| raw_in | input | 16 | Raw level flags; bits 7..5 are not used |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| addr | input | 4 | Register address for both reads and writes |
| wr_data | input | 8 | Write data byte |
| rd_data | output | 8 | Combinational read data for `addr` |
| irq_a | output | 1 | Interrupt line qualified by mask set A |
| irq_b | output | 1 | Interrupt line qualified by mask set B |

## Verification
The raw flags are driven in several kinds of patterns, and each kind separates a different fault:

- Single rising and single falling toggles show that both directions latch, which a rising-only detector would not do.
- A toggle-back pattern separates a sticky bit from one that follows the raw level.
- A nonzero level held through reset, and the unused flag bits, show that no false event appears.
- A toggle timed onto the same edge as a clear write checks that the set wins.

A random phase then mixes flag toggles, clear writes with partial bit patterns, mask writes and reads at every address. It compares every read and both interrupt lines against a bench model. This exposes masks routed to the wrong line and clear bits that reach the wrong word.

// File: rtl/chg_irq_pkg.sv
// Package: shared sizes and the register map of the change-detect
// interrupt controller. Assumes byte-wide status words.
package chg_irq_pkg;
    localparam int DW   = 8;   // bits per register word
    localparam int NREG = 2;   // number of status words
    localparam int AW   = 4;   // register address width
    // live status bit positions; word 0 uses bits 4..0 only
    localparam logic [NREG*DW-1:0] VALID_MAP = 16'hFF1F;
    // base addresses of each register group (one word per status word)
    localparam int A_STAT = 0;
    localparam int A_CLR  = NREG;
    localparam int A_MSKA = 2 * NREG;
    localparam int A_MSKB = 3 * NREG;
endpackage

// File: rtl/chg_detect.sv
// Change detector: registers the raw flags once and compares the
// registered value with the value one cycle older. Assumes the raw flags
// are already synchronous to clk. During reset both stages load the
// current input, so leaving reset never reports a change.
module chg_detect #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_in,
    output logic [W-1:0] chg
);
    logic [W-1:0] raw_q;
    logic [W-1:0] prev_q;

    // sample stage and history stage; both preload on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_q  <= raw_in;
            prev_q <= raw_in;
        end else begin
            raw_q  <= raw_in;
            prev_q <= raw_q;
        end
    end

    // any difference between samples is an event, in either direction
    always_comb chg = raw_q ^ prev_q;
endmodule

// File: rtl/status_bank.sv
// Sticky status bank: one word per status register. A bit sets on a
// change event and clears only on a clear pulse; set wins over clear.
// Bits outside VALID are held at 0. Assumes clr is a one-cycle pulse.
module status_bank #(
    parameter int                 DW    = 8,
    parameter int                 NREG  = 2,
    parameter logic [NREG*DW-1:0] VALID = '1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NREG*DW-1:0] chg,
    input  logic [NREG*DW-1:0] clr,
    output logic [NREG*DW-1:0] status
);
    for (genvar r = 0; r < NREG; r++) begin : g_word
        localparam int LO = r * DW;
        logic [DW-1:0] stat_q;

        // per-word sticky update with set priority over clear
        always_ff @(posedge clk) begin
            if (!rst_n)
                stat_q <= '0;
            else
                stat_q <= ((stat_q & ~clr[LO +: DW]) | chg[LO +: DW])
                          & VALID[LO +: DW];
        end

        assign status[LO +: DW] = stat_q;
    end
endmodule

// File: rtl/reg_port.sv
// Register port: decodes byte writes into clear pulses and mask updates,
// and muxes read data. Reads are combinational on addr. Assumes at most
// one write per cycle. Unmapped addresses read 0 and ignore writes.
module reg_port
    import chg_irq_pkg::*;
#(
    parameter int DWP   = DW,
    parameter int NREGP = NREG,
    parameter int AWP   = AW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [AWP-1:0]       addr,
    input  logic [DWP-1:0]       wr_data,
    input  logic [NREGP*DWP-1:0] status,
    output logic [DWP-1:0]       rd_data,
    output logic [NREGP*DWP-1:0] clr,
    output logic [NREGP*DWP-1:0] mask_a,
    output logic [NREGP*DWP-1:0] mask_b
);
    logic [NREGP*DWP-1:0] rd_terms;

    for (genvar r = 0; r < NREGP; r++) begin : g_word
        localparam int LO = r * DWP;
        localparam logic [AWP-1:0] AD_STAT = AWP'(A_STAT + r);
        localparam logic [AWP-1:0] AD_CLR  = AWP'(A_CLR  + r);
        localparam logic [AWP-1:0] AD_MSKA = AWP'(A_MSKA + r);
        localparam logic [AWP-1:0] AD_MSKB = AWP'(A_MSKB + r);
        logic [DWP-1:0] mska_q;
        logic [DWP-1:0] mskb_q;

        // clear pulse exists only during the write cycle
        assign clr[LO +: DWP] = (wr_en && addr == AD_CLR) ? wr_data : '0;

        // mask set A and B byte storage
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mska_q <= '0;
                mskb_q <= '0;
            end else if (wr_en) begin
                if (addr == AD_MSKA) mska_q <= wr_data;
                if (addr == AD_MSKB) mskb_q <= wr_data;
            end
        end

        assign mask_a[LO +: DWP] = mska_q;
        assign mask_b[LO +: DWP] = mskb_q;

        // this word's contribution to the read mux
        always_comb begin
            rd_terms[LO +: DWP] = '0;
            if (addr == AD_STAT) rd_terms[LO +: DWP] = status[LO +: DWP];
            if (addr == AD_MSKA) rd_terms[LO +: DWP] = mska_q;
            if (addr == AD_MSKB) rd_terms[LO +: DWP] = mskb_q;
        end
    end

    // OR-reduce word contributions; at most one is nonzero
    always_comb begin
        rd_data = '0;
        for (int r = 0; r < NREGP; r++)
            rd_data = rd_data | rd_terms[r*DWP +: DWP];
    end
endmodule

// File: rtl/irq_gen.sv
// Interrupt generator: each line is the OR of status bits qualified by
// that line's own mask. Assumes level-type outputs, active high.
module irq_gen #(
    parameter int W = 16
) (
    input  logic [W-1:0] status,
    input  logic [W-1:0] mask_a,
    input  logic [W-1:0] mask_b,
    output logic         irq_a,
    output logic         irq_b
);
    // two independent reductions
    always_comb begin
        irq_a = |(status & mask_a);
        irq_b = |(status & mask_b);
    end
endmodule

// File: rtl/chg_irq_ctrl.sv
// Top: change-detect interrupt status controller. Raw flags feed a
// change detector, events latch in a sticky bank, a register port
// handles masks/clears/reads and two mask sets drive two interrupt lines.
module chg_irq_ctrl
    import chg_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NREG*DW-1:0] raw_in,
    input  logic               wr_en,
    input  logic [AW-1:0]      addr,
    input  logic [DW-1:0]      wr_data,
    output logic [DW-1:0]      rd_data,
    output logic               irq_a,
    output logic               irq_b
);
    localparam int W = NREG * DW;

    logic [W-1:0] chg_w;
    logic [W-1:0] clr_w;
    logic [W-1:0] stat_w;
    logic [W-1:0] mask_a_w;
    logic [W-1:0] mask_b_w;

    chg_detect #(.W(W)) u_det (
        .clk(clk), .rst_n(rst_n), .raw_in(raw_in), .chg(chg_w)
    );

    status_bank #(.DW(DW), .NREG(NREG), .VALID(VALID_MAP)) u_stat (
        .clk(clk), .rst_n(rst_n), .chg(chg_w), .clr(clr_w), .status(stat_w)
    );

    reg_port #(.DWP(DW), .NREGP(NREG), .AWP(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .status(stat_w), .rd_data(rd_data),
        .clr(clr_w), .mask_a(mask_a_w), .mask_b(mask_b_w)
    );

    irq_gen #(.W(W)) u_irq (
        .status(stat_w), .mask_a(mask_a_w), .mask_b(mask_b_w),
        .irq_a(irq_a), .irq_b(irq_b)
    );
endmodule

// File: rtl/chg_irq_ctrl_chk.sv
// Checker: temporal properties on the controller's internal nets.
module chg_irq_ctrl_chk
    import chg_irq_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic [NREG*DW-1:0] chg,
    input logic [NREG*DW-1:0] clr,
    input logic [NREG*DW-1:0] status,
    input logic [NREG*DW-1:0] mask_a,
    input logic [NREG*DW-1:0] mask_b,
    input logic               irq_a,
    input logic               irq_b
);
    // R2 and R3: a live change is latched on the next edge
    p_set_on_change_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status & $past(chg & VALID_MAP)) == $past(chg & VALID_MAP)));

    // R4: a set bit without a clear pulse stays set
    p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(status) & ~$past(clr) & ~status) == '0));

    // R5: a clear without a concurrent change drops the bit
    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status & $past(clr & ~chg)) == '0));

    // R8: unused positions never set
    p_unused_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (status & ~VALID_MAP) == '0);

    // R10: a line with an empty mask stays low
    p_irq_a_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_a == '0) |-> !irq_a);
    p_irq_b_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_b == '0) |-> !irq_b);

    // R1: nothing is pending in the first cycle after reset
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (status == '0 && !irq_a && !irq_b));
endmodule

bind chg_irq_ctrl chg_irq_ctrl_chk chk_i (
    .clk(clk), .rst_n(rst_n), .chg(chg_w), .clr(clr_w), .status(stat_w),
    .mask_a(mask_a_w), .mask_b(mask_b_w), .irq_a(irq_a), .irq_b(irq_b)
);

// File: tb/chg_irq_ctrl_tb_top.sv
module chg_irq_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] VMAP = 16'hFF1F;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [15:0] raw_in = '0;
    logic       wr_en = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       irq_a, irq_b;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // bench model state
    logic [15:0] m_rawq, m_prev, m_stat, m_ma, m_mb;

    always #(CLK_PERIOD/2) clk = ~clk;

    chg_irq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .raw_in(raw_in), .wr_en(wr_en),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
        .irq_a(irq_a), .irq_b(irq_b)
    );

    function automatic logic [7:0] exp_rd(input logic [3:0] a);
        case (a)
            4'h0: return m_stat[7:0];
            4'h1: return m_stat[15:8];
            4'h4: return m_ma[7:0];
            4'h5: return m_ma[15:8];
            4'h6: return m_mb[7:0];
            4'h7: return m_mb[15:8];
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one clock: drive inputs, advance model on the edge
    task automatic cyc(input logic [15:0] raw, input logic we,
                       input logic [3:0] a, input logic [7:0] d);
        logic [15:0] clrv;
        raw_in = raw; wr_en = we; addr = a; wr_data = d;
        clrv = '0;
        if (we && a == 4'h2) clrv[7:0]  = d;
        if (we && a == 4'h3) clrv[15:8] = d;
        @(posedge clk);
        if (!rst_n) begin
            m_rawq = raw; m_prev = raw; m_stat = '0; m_ma = '0; m_mb = '0;
        end else begin
            m_stat = ((m_stat & ~clrv) | (m_rawq ^ m_prev)) & VMAP;
            m_prev = m_rawq;
            m_rawq = raw;
            if (we && a == 4'h4) m_ma[7:0]  = d;
            if (we && a == 4'h5) m_ma[15:8] = d;
            if (we && a == 4'h6) m_mb[7:0]  = d;
            if (we && a == 4'h7) m_mb[15:8] = d;
        end
        #1;
        wr_en = 1'b0;
    endtask

    task automatic check_rd(input logic [3:0] a, input string tag);
        wr_en = 1'b0; addr = a;
        #1;
        chk({8'h00, rd_data}, {8'h00, exp_rd(a)}, tag);
    endtask

    task automatic check_irq(input string tag);
        chk({14'h0, irq_a, irq_b},
            {14'h0, |(m_stat & m_ma), |(m_stat & m_mb)}, tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(raw_in, 1'b0, 4'h0, 8'h00);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] r;
        void'($urandom(32'd1234));
        // reset with a nonzero raw level
        rst_n = 1'b0;
        for (int i = 0; i < 3; i++) cyc(16'h00A5, 1'b0, 4'h0, 8'h00);
        rst_n = 1'b1;
        cyc(16'h00A5, 1'b0, 4'h0, 8'h00);
        check_rd(4'h0, "R1 stat0 after reset");
        check_rd(4'h1, "R1 stat1 after reset");
        check_rd(4'h4, "R1 maskA reset");
        check_rd(4'h7, "R1 maskB reset");
        idle(2);
        check_rd(4'h0, "R1 no event from reset");
        chk({14'h0, irq_a, irq_b}, 16'h0, "R1 irq low");

        // bit1 rises, bit0 falls
        cyc(16'h00A6, 1'b0, 4'h0, 8'h00);
        check_rd(4'h0, "R2 not yet visible");
        chk({8'h0, rd_data}, 16'h0000, "R2 latency");
        cyc(16'h00A6, 1'b0, 4'h0, 8'h00);
        check_rd(4'h0, "R2 R3 both directions");
        chk({8'h0, rd_data}, 16'h0003, "R3 fall and R2 rise");

        // toggle back: must stay set
        cyc(16'h00A5, 1'b0, 4'h0, 8'h00);
        idle(2);
        chk({8'h0, exp_rd(4'h0)}, 16'h0003, "R4 model sanity");
        check_rd(4'h0, "R4 sticky");

        // partial clear
        cyc(16'h00A5, 1'b1, 4'h2, 8'h01);
        check_rd(4'h0, "R5 clear bit0 only");
        check_rd(4'h2, "R5 clear reads zero");
        check_rd(4'h3, "R5 clear1 reads zero");

        // set and clear on the same edge
        cyc(16'h00A1, 1'b0, 4'h0, 8'h00);
        cyc(16'h00A1, 1'b1, 4'h2, 8'h04);
        check_rd(4'h0, "R6 set wins");
        chk({8'h0, rd_data}, 16'h0006, "R6 bit2 kept");

        // write to status ignored
        cyc(16'h00A1, 1'b1, 4'h0, 8'h00);
        cyc(16'h00A1, 1'b1, 4'h1, 8'hFF);
        check_rd(4'h0, "R7 stat0 read-only");
        check_rd(4'h1, "R7 stat1 read-only");

        // unused raw bits
        cyc(16'h0041, 1'b0, 4'h0, 8'h00);
        cyc(16'h00E1, 1'b0, 4'h0, 8'h00);
        idle(2);
        check_rd(4'h0, "R8 bits 7..5 zero");
        // word 1 mapping
        cyc(16'h80E1, 1'b0, 4'h0, 8'h00);
        idle(2);
        check_rd(4'h1, "R8 raw15 to word1 bit7");

        // masks and irq routing
        cyc(raw_in, 1'b1, 4'h4, 8'hF0);
        check_rd(4'h4, "R9 maskA0 readback");
        check_irq("R10 maskA no overlap");
        cyc(raw_in, 1'b1, 4'h7, 8'h80);
        check_rd(4'h7, "R9 maskB1 readback");
        check_irq("R10 irq_b from word1");
        cyc(raw_in, 1'b1, 4'h4, 8'h02);
        check_irq("R10 irq_a from word0");

        // unmapped
        cyc(raw_in, 1'b1, 4'h9, 8'hFF);
        cyc(raw_in, 1'b1, 4'hF, 8'hFF);
        for (int a = 8; a < 16; a++) check_rd(4'(a), "R11 unmapped reads 0");
        for (int a = 0; a < 8; a++) check_rd(4'(a), "R11 no side effect");

        // random mix
        r = raw_in;
        for (int i = 0; i < 600; i++) begin
            int k;
            if ($urandom_range(0, 2) == 0) r = r ^ (16'h1 << $urandom_range(0, 15));
            k = $urandom_range(0, 9);
            if (k < 3)
                cyc(r, 1'b1, 4'($urandom_range(2, 3)), 8'($urandom));
            else if (k < 5)
                cyc(r, 1'b1, 4'($urandom_range(4, 7)), 8'($urandom));
            else if (k == 5)
                cyc(r, 1'b1, 4'($urandom_range(0, 15)), 8'($urandom));
            else
                cyc(r, 1'b0, 4'h0, 8'h00);
            check_rd(4'($urandom_range(0, 15)), "R10 R5 R9 random read");
            check_irq("R10 random irq");
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule